// File: doc/BRIEF.md
# Dual Capture/Compare Timer Counter

This block holds two identical 32-bit timer counters behind a plain synchronous word-register port. A write is taken on the rising clock edge when `wrEn` is high. Read data is combinational from `addr`. Each counter has its own 16-byte window. Within a window the control/status word sits at byte offset 0, the load word at offset 4 and the live count at offset 8. Counter 1's window starts 16 bytes above counter 0's.

In compare mode a counter steps up or down from a value copied out of its load word. When it reaches its terminal value it either reloads and keeps running or stops and holds. Each terminal event can raise a one-cycle pulse on a generate output. In capture mode the counter runs freely. A rising edge on its synchronised capture input copies the running count into the load word. Either kind of event sets a sticky flag. The flag is cleared by writing 1 to it, and it drives a maskable interrupt. A single write can start both counters in the same cycle.

Top module: `dual_cc_timer`

## Requirements
- R1: Byte address bit 4 selects the counter. Bits 3:2 select the word within the window: 0 is control/status, 1 is load, 2 is count; word 3 reads zero. Bits 1:0 must be zero for a write to take effect. After reset every word reads zero and all outputs are low. The load word is read/write. Writes to the count word are ignored.
- R2: While control bit 5 is 1, the count takes the load word's value on every clock edge and does not advance.
- R3: With control bit 7 (enable) set and bit 5 clear, the count changes by one on every edge. It counts up when bit 1 is 0 and down when bit 1 is 1.
- R4: In compare mode (bit 0 = 0), the terminal value is all-ones when counting up and zero when counting down. The terminal event lasts the single cycle in which the enabled count equals the terminal value. If bit 4 is set, the next edge reloads the count from the load word.
- R5: If bit 4 is clear, the count stays at the terminal value after the terminal event, and the enable bit reads back 0 from the next cycle on.
- R6: When control bit 2 is set, `genOut` is high exactly during the terminal-event cycle. It stays low while bit 2 is clear.
- R7: Control bit 8 is the event flag. It becomes 1 on the edge after a terminal or capture event. Writing 1 to bit 8 clears it. Writing 0 to bit 8 leaves it unchanged.
- R8: `irqOut[i]` is counter i's flag ANDed with its control bit 6, and `irq` is the OR of both.
- R9: A control write with bit 10 set, to either counter, sets the enable bit of both counters on the same edge. Bit 10 reads back 0.
- R10: In capture mode (bit 0 = 1) with bit 3 set, `capIn[i]` goes through a two-flop synchroniser and is edge-detected. The count present two edges after the input rises is written into the load word on the third edge. With bit 3 clear, the input is ignored.
- R11: In capture mode with bit 4 clear, a capture is blocked while the flag is set. With bit 4 set, every capture overwrites the load word.
- R12: If a flag-clear write lands on the same edge as a new event, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| capIn | input | 2 | Asynchronous capture inputs, one per counter |
| genOut | output | 2 | Terminal-event pulses, one per counter |
| irqOut | output | 2 | Per-counter masked interrupts |
| irq | output | 1 | OR of both interrupts |

## Verification
A control write takes effect on the edge that ends the write cycle. A count or load value affected by that write is read at the following falling edge. `genOut` is high during the terminal cycle itself, while the flag and `irqOut` rise one edge later. A capture shows up in the load word three edges after `capIn` rises, holding the count read at the moment `capIn` was driven plus two. The bench drives and samples only at falling edges and advances a counted number of edges before each read. In every check it compares against values computed arithmetically from the load value and the elapsed edges.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  parameter int DATA_W = 32;

  localparam int BIT_CAP_MODE = 0;
  localparam int BIT_DOWN     = 1;
  localparam int BIT_GEN_EN   = 2;
  localparam int BIT_CAP_EN   = 3;
  localparam int BIT_AUTO_RLD = 4;
  localparam int BIT_LOAD     = 5;
  localparam int BIT_INT_EN   = 6;
  localparam int BIT_ENABLE   = 7;
  localparam int BIT_FLAG     = 8;
  localparam int BIT_EN_ALL   = 10;

  localparam logic [1:0] REG_CSR   = 2'd0;
  localparam logic [1:0] REG_LOAD  = 2'd1;
  localparam logic [1:0] REG_COUNT = 2'd2;

  // control -> datapath strobes, one per counter
  typedef struct packed {
    logic              enable;
    logic              load;
    logic              down;
    logic              capMode;
    logic              autoReload;
    logic              genEn;
    logic              capEn;
    logic              flag;
    logic [DATA_W-1:0] loadVal;
  } ctrlStb_t;

  // datapath -> control events, one per counter
  typedef struct packed {
    logic              tcEvt;
    logic              capEvt;
    logic [DATA_W-1:0] count;
  } dpEvt_t;
endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int ADDR_W  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  dpEvt_t   [NUM_CNT-1:0]     dpEvt,
  output ctrlStb_t [NUM_CNT-1:0]     ctrlStb,
  output logic     [NUM_CNT-1:0]     irqOut
);
  localparam int SEL_W = ADDR_W - 4;
  localparam logic [SEL_W:0] NUM_CNT_V = (SEL_W+1)'(NUM_CNT);

  logic [SEL_W-1:0] winSel;
  logic [1:0]       regSel;
  logic             wordAligned;
  logic             enAllWr;
  logic [NUM_CNT-1:0][DATA_W-1:0] rdWord;

  assign winSel      = addr[ADDR_W-1:4];
  assign regSel      = addr[3:2];
  assign wordAligned = (addr[1:0] == 2'b00);
  assign enAllWr     = wrEn && wordAligned && (regSel == REG_CSR) && wrData[BIT_EN_ALL];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [BIT_ENABLE:0] csrQ;
    logic                flagQ;
    logic [DATA_W-1:0]   loadQ;
    logic                csrWr, ldWr, stopNow, enNext;

    assign csrWr   = wrEn && wordAligned && (winSel == SEL_W'(i)) && (regSel == REG_CSR);
    assign ldWr    = wrEn && wordAligned && (winSel == SEL_W'(i)) && (regSel == REG_LOAD);
    assign stopNow = dpEvt[i].tcEvt && !csrQ[BIT_AUTO_RLD];

    // enable priority: global start, then own write, then terminal stop
    always_comb begin
      enNext = csrQ[BIT_ENABLE];
      if (stopNow) enNext = 1'b0;
      if (csrWr)   enNext = wrData[BIT_ENABLE];
      if (enAllWr) enNext = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        csrQ  <= '0;
        flagQ <= 1'b0;
        loadQ <= '0;
      end else begin
        if (csrWr) csrQ[BIT_ENABLE-1:0] <= wrData[BIT_ENABLE-1:0];
        csrQ[BIT_ENABLE] <= enNext;
        if (dpEvt[i].tcEvt || dpEvt[i].capEvt) flagQ <= 1'b1;
        else if (csrWr && wrData[BIT_FLAG])    flagQ <= 1'b0;
        if (dpEvt[i].capEvt) loadQ <= dpEvt[i].count;
        else if (ldWr)       loadQ <= wrData;
      end
    end

    assign ctrlStb[i].enable     = csrQ[BIT_ENABLE];
    assign ctrlStb[i].load       = csrQ[BIT_LOAD];
    assign ctrlStb[i].down       = csrQ[BIT_DOWN];
    assign ctrlStb[i].capMode    = csrQ[BIT_CAP_MODE];
    assign ctrlStb[i].autoReload = csrQ[BIT_AUTO_RLD];
    assign ctrlStb[i].genEn      = csrQ[BIT_GEN_EN];
    assign ctrlStb[i].capEn      = csrQ[BIT_CAP_EN];
    assign ctrlStb[i].flag       = flagQ;
    assign ctrlStb[i].loadVal    = loadQ;

    assign irqOut[i] = flagQ && csrQ[BIT_INT_EN];

    always_comb begin
      unique case (regSel)
        REG_CSR:   rdWord[i] = DATA_W'({flagQ, csrQ});
        REG_LOAD:  rdWord[i] = loadQ;
        REG_COUNT: rdWord[i] = dpEvt[i].count;
        default:   rdWord[i] = '0;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    if ({1'b0, winSel} < NUM_CNT_V) rdData = rdWord[winSel];
  end
endmodule

// File: rtl/dcc_datapath.sv
module dcc_datapath
  import dcc_pkg::*;
#(
  parameter int NUM_CNT = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStb_t [NUM_CNT-1:0] ctrlStb,
  input  logic     [NUM_CNT-1:0] capIn,
  output dpEvt_t   [NUM_CNT-1:0] dpEvt,
  output logic     [NUM_CNT-1:0] genOut
);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);
  localparam logic [DATA_W-1:0] ALL_ONE = '1;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic              syncA, syncB, syncPrev;
    logic [DATA_W-1:0] cntQ;
    logic [DATA_W-1:0] termVal;
    logic              rise, tcEvt, capEvt;
    ctrlStb_t          stb;

    assign stb     = ctrlStb[i];
    assign rise    = syncB && !syncPrev;
    assign termVal = stb.down ? '0 : ALL_ONE;
    assign tcEvt   = stb.enable && !stb.load && !stb.capMode && (cntQ == termVal);
    assign capEvt  = stb.capMode && stb.capEn && rise && (stb.autoReload || !stb.flag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA    <= 1'b0;
        syncB    <= 1'b0;
        syncPrev <= 1'b0;
        cntQ     <= '0;
      end else begin
        syncA    <= capIn[i];
        syncB    <= syncA;
        syncPrev <= syncB;
        if (stb.load) begin
          cntQ <= stb.loadVal;
        end else if (stb.enable) begin
          if (tcEvt) begin
            if (stb.autoReload) cntQ <= stb.loadVal;
          end else if (stb.down) begin
            cntQ <= cntQ - ONE;
          end else begin
            cntQ <= cntQ + ONE;
          end
        end
      end
    end

    assign dpEvt[i].tcEvt  = tcEvt;
    assign dpEvt[i].capEvt = capEvt;
    assign dpEvt[i].count  = cntQ;
    assign genOut[i]       = tcEvt && stb.genEn;
  end
endmodule

// File: rtl/dual_cc_timer.sv
module dual_cc_timer
  import dcc_pkg::*;
#(
  parameter  int NUM_CNT = 2,
  localparam int ADDR_W  = $clog2(NUM_CNT) + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_CNT-1:0] capIn,
  output logic [NUM_CNT-1:0] genOut,
  output logic [NUM_CNT-1:0] irqOut,
  output logic               irq
);
  ctrlStb_t [NUM_CNT-1:0] ctrlStb;
  dpEvt_t   [NUM_CNT-1:0] dpEvt;

  dcc_ctrl #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dpEvt(dpEvt), .ctrlStb(ctrlStb), .irqOut(irqOut)
  );

  dcc_datapath #(.NUM_CNT(NUM_CNT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlStb(ctrlStb), .capIn(capIn),
    .dpEvt(dpEvt), .genOut(genOut)
  );

  assign irq = |irqOut;
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker
  import dcc_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int ADDR_W  = 5
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [DATA_W-1:0]      wrData,
  input ctrlStb_t [NUM_CNT-1:0] ctrlStb,
  input dpEvt_t   [NUM_CNT-1:0] dpEvt,
  input logic [NUM_CNT-1:0]     genOut
);
  localparam int LAST = NUM_CNT - 1;

  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb[0].load |=> dpEvt[0].count == $past(ctrlStb[0].loadVal));

  p_count_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb[0].enable && !ctrlStb[0].load && !ctrlStb[0].down &&
     !ctrlStb[0].capMode && !dpEvt[0].tcEvt)
    |=> dpEvt[0].count == $past(dpEvt[0].count) + DATA_W'(1));

  p_hold_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dpEvt[0].tcEvt && !ctrlStb[0].autoReload && !wrEn)
    |=> !ctrlStb[0].enable && dpEvt[0].count == $past(dpEvt[0].count));

  p_gen_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    genOut[0] |=> ctrlStb[0].flag);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0 && wrData[BIT_FLAG] && !dpEvt[0].tcEvt && !dpEvt[0].capEvt)
    |=> !ctrlStb[0].flag);

  p_enable_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[3:0] == 4'd0 && wrData[BIT_EN_ALL])
    |=> ctrlStb[0].enable && ctrlStb[LAST].enable);

  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    dpEvt[LAST].capEvt
    |=> ctrlStb[LAST].loadVal == $past(dpEvt[LAST].count) && ctrlStb[LAST].flag);
endmodule

bind dual_cc_timer dcc_checker #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .ctrlStb(ctrlStb), .dpEvt(dpEvt), .genOut(genOut)
);

// File: tb/tb_dual_cc_timer.sv
module tb_dual_cc_timer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [4:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [1:0]  capIn;
  logic [1:0]  genOut;
  logic [1:0]  irqOut;
  logic        irq;

  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  dual_cc_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .capIn(capIn), .genOut(genOut), .irqOut(irqOut), .irq(irq)
  );

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(int idx, int rs, logic [31:0] d);
    addr   = 5'((idx << 4) | (rs << 2));
    wrData = d;
    wrEn   = 1'b1;
    tick();
    wrEn   = 1'b0;
  endtask

  task automatic rd(int idx, int rs, output logic [31:0] v);
    addr = 5'((idx << 4) | (rs << 2));
    #1;
    v = rdData;
  endtask

  task automatic printSummary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    printSummary();
    $finish;
  end

  initial begin
    logic [31:0] v, c, a;
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; capIn = '0;
    tick(3);
    rstN = 1'b1;
    tick();

    // R1 reset state and map
    for (int i = 0; i < 2; i++)
      for (int r = 0; r < 4; r++) begin
        rd(i, r, v);
        chk("R1 reset word", v, 32'd0);
      end
    chk("R1 reset outputs", {27'd0, genOut, irqOut, irq}, 32'd0);
    wr(0, 1, 32'h1234_5678);
    wr(1, 1, 32'h0000_CAFE);
    rd(0, 1, v); chk("R1 load0 readback", v, 32'h1234_5678);
    rd(1, 1, v); chk("R1 load1 readback", v, 32'h0000_CAFE);
    wr(0, 2, 32'hDEAD_BEEF);
    rd(0, 2, v); chk("R1 count write ignored", v, 32'd0);
    rd(0, 3, v); chk("R1 word3 zero", v, 32'd0);

    // R2 load freezes, R3 up count
    wr(0, 1, 32'd100);
    wr(0, 0, 32'h20);
    wr(0, 0, 32'hA0);
    tick(3);
    rd(0, 2, v); chk("R2 count frozen during load", v, 32'd100);
    wr(0, 0, 32'h80);
    rd(0, 2, v); chk("R3 start value", v, 32'd100);
    tick(5);
    rd(0, 2, v); chk("R3 up count", v, 32'd105);

    // R3 down count
    wr(1, 1, 32'd50);
    wr(1, 0, 32'h20);
    wr(1, 0, 32'h82);
    tick(7);
    rd(1, 2, v); chk("R3 down count", v, 32'd43);
    wr(1, 0, 32'h00);

    // R4 auto-reload up, R6 gen pulse, R7 flag, R8 irq
    wr(0, 1, 32'hFFFF_FFFD);
    wr(0, 0, 32'h20);
    wr(0, 0, 32'hD4);
    rd(0, 2, v); chk("R4 reload start", v, 32'hFFFF_FFFD);
    chk("R6 gen low before terminal", {30'd0, genOut}, 32'd0);
    tick(2);
    rd(0, 2, v); chk("R4 at terminal", v, 32'hFFFF_FFFF);
    chk("R6 gen pulse on terminal", {31'd0, genOut[0]}, 32'd1);
    chk("R8 irq low before flag", {31'd0, irq}, 32'd0);
    tick();
    rd(0, 2, v); chk("R4 reloaded", v, 32'hFFFF_FFFD);
    chk("R6 gen single cycle", {31'd0, genOut[0]}, 32'd0);
    chk("R8 irq after event", {29'd0, irqOut, irq}, 32'd3);
    rd(0, 0, v); chk("R7 flag set", v, 32'h1D4);
    wr(0, 0, 32'h44);
    rd(0, 0, v); chk("R7 write 0 keeps flag", v, 32'h144);
    wr(0, 0, 32'h140);
    rd(0, 0, v); chk("R7 write 1 clears flag", v, 32'h40);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);

    // R5 hold on terminal, down, gen and int disabled
    wr(1, 1, 32'd2);
    wr(1, 0, 32'h20);
    wr(1, 0, 32'h82);
    tick(2);
    rd(1, 2, v); chk("R5 reached zero", v, 32'd0);
    chk("R6 gen off when bit2 clear", {31'd0, genOut[1]}, 32'd0);
    tick(4);
    rd(1, 2, v); chk("R5 held at zero", v, 32'd0);
    rd(1, 0, v); chk("R5 enable cleared, flag set", v, 32'h102);
    chk("R8 masked irq", {30'd0, irqOut}, 32'd0);
    wr(1, 0, 32'h40);
    chk("R8 irq unmasked", {29'd0, irqOut, irq}, 32'd5);
    wr(1, 0, 32'h100);

    // R9 enable all
    wr(0, 1, 32'd10);
    wr(1, 1, 32'd20);
    wr(0, 0, 32'h20);
    wr(1, 0, 32'h20);
    wr(0, 0, 32'h00);
    wr(1, 0, 32'h400);
    tick(4);
    rd(0, 2, v); chk("R9 counter0 started", v, 32'd14);
    rd(1, 2, v); chk("R9 counter1 started", v, 32'd24);
    rd(0, 0, v); chk("R9 counter0 enable", v, 32'h80);
    rd(1, 0, v); chk("R9 counter1 enable, bit10 reads 0", v, 32'h80);
    wr(0, 0, 32'h0);
    wr(1, 0, 32'h0);

    // R10 capture while running
    wr(1, 1, 32'h500);
    wr(1, 0, 32'h20);
    wr(1, 0, 32'hC9);
    rd(1, 2, c);
    capIn[1] = 1'b1;
    tick(3);
    rd(1, 1, v); chk("R10 captured value", v, c + 32'd2);
    rd(1, 0, v); chk("R10 flag set", v, 32'h1C9);
    chk("R10 irq", {30'd0, irqOut}, 32'd2);
    capIn[1] = 1'b0;
    tick(3);

    // R11 hold first capture while flag set
    a = c + 32'd2;
    capIn[1] = 1'b1;
    tick(3);
    rd(1, 1, v); chk("R11 capture held", v, a);
    capIn[1] = 1'b0;
    tick(3);

    // R11 overwrite with bit4
    wr(1, 0, 32'hD9);
    rd(1, 2, c);
    capIn[1] = 1'b1;
    tick(3);
    rd(1, 1, v); chk("R11 capture overwritten", v, c + 32'd2);
    capIn[1] = 1'b0;
    tick(3);

    // R12 event beats clear
    rd(1, 2, c);
    capIn[1] = 1'b1;
    tick(2);
    wr(1, 0, 32'h1D9);
    rd(1, 0, v); chk("R12 flag kept", v, 32'h1D9);
    rd(1, 1, v); chk("R12 capture taken", v, c + 32'd2);
    wr(1, 0, 32'h1D9);
    rd(1, 0, v); chk("R7 flag cleared later", v, 32'hD9);
    capIn[1] = 1'b0;
    tick(3);

    // R10 capture input ignored with bit3 clear
    wr(1, 0, 32'hC1);
    rd(1, 1, a);
    capIn[1] = 1'b1;
    tick(4);
    rd(1, 1, v); chk("R10 no capture without bit3", v, a);
    rd(1, 0, v); chk("R10 no flag without bit3", v, 32'hC1);
    capIn[1] = 1'b0;

    printSummary();
    $finish;
  end
endmodule